// File: doc/BRIEF.md
# Primary-Side Flyback Output-Current Estimator

This block estimates the output current of a flyback converter using only quantities seen on the primary side. It takes one digitized sample per clock of the auxiliary-winding sense voltage and of the current-sense voltage, together with the gate drive. Once per switching cycle it captures the switch current at the middle of the on-time. During the off-time it measures how long the secondary diode conducts by finding the knee in the winding voltage. At the start of the next cycle it combines these with the switching period into a current estimate.

The estimate drives an integrating current-loop control value. A comparator stage turns both that value and an external voltage-loop value into one turn-off request against a sawtooth, so whichever loop asks for the shorter pulse ends it. All sample values are 12-bit codes. With 5 V full scale, 164 codes is about 200 mV and 2048 codes is about 2.5 V.

Top module: `fb_iest`

## Requirements
- R1: While reset is held and after its release, before any estimate, `tdis` = 0, `iout` = 0, `comi` = 4095 and `est_valid` = 0.
- R2: On-time positions are numbered from 1 at the first clock that samples `gate` high. The current-sense sample for a cycle is taken at position max(floor(T/2), BLANK+1), where T is the previous cycle's on-time count (16 before the first full on-time). If the gate falls before that position, the sample from an earlier cycle is kept.
- R3: Off-time positions are numbered from 1 at the first clock that samples `gate` low. The knee reference is the sense sample at off-position max(floor(D*218/256), BLANK+1), where D is the previous cycle's `tdis`. If no cycle has finished yet, 16 is used in place of the floor(D*218/256) term.
- R4: A zero crossing occurs at the first off-position after the reference where `vs_smp` + 164 < reference. `tdis` then becomes that position. A drop of 164 codes or less is never a crossing.
- R5: If no crossing occurs before the gate rises again, `tdis` is set to the number of off-time samples of that cycle.
- R6: Samples at positions 1 to BLANK (BLANK = 4) after either gate edge never become the current sample, the knee reference or a crossing.
- R7: Each rise of `gate` that follows a complete off-time pulses `est_valid` for one clock, two clocks after `gate` is first sampled high. With it, `iout` = floor(C*D*floor(65536/P)/65536). C is the current sample (R2), D is `tdis`, and P is on-time plus off-time, clamped to 16..1023. The first rise after reset gives no estimate.
- R8: With each estimate, `comi` becomes clamp(`comi` + ((2048 - `iout`) >>> 2), 0, 4095), using an arithmetic shift. Otherwise `comi` holds.
- R9: `turn_off` is 1 exactly when `saw` >= `comv` or `saw` >= `comi`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gate | input | 1 | Gate drive, 1 while the switch is on |
| vs_smp | input | 12 | Auxiliary-winding sense sample |
| cs_smp | input | 12 | Current-sense sample |
| comv | input | 12 | Voltage-loop control value |
| saw | input | 12 | Sawtooth value |
| tdis | output | 16 | Measured discharge time in clocks (CNT_W = 16 by default) |
| iout | output | 12 | Output-current estimate |
| comi | output | 12 | Current-loop control value |
| est_valid | output | 1 | One-clock strobe marking a new estimate |
| turn_off | output | 1 | Turn-off request from either loop |

## Verification
A new `tdis` from a crossing is visible one clock after the sample that shows the drop. A clipped `tdis` appears on the clock that samples the gate high. `iout` and `comi` change together with `est_valid`, one clock after that. `turn_off` follows its inputs within the same clock. The bench works out the expected discharge time, estimate and control value for every cycle it drives and queues them. It compares them only while `est_valid` is high, sampling on the falling clock edge. The comparator checks sample half a clock after the inputs are set.

// File: rtl/fb_iest_pkg.sv
package fb_iest_pkg;

  // Lower bound on a sample position so it stays clear of blanking.
  function automatic logic [31:0] pos_floor(input logic [31:0] want, input logic [31:0] lo);
    return (want < lo) ? lo : want;
  endfunction

  // Fraction of the previous discharge time where the knee reference is taken.
  function automatic logic [31:0] knee_delay(input logic [31:0] t, input logic [31:0] num, input int sh);
    return (t * num) >> sh;
  endfunction

  // Current sample times discharge time times period reciprocal.
  function automatic logic [63:0] scale_est(input logic [63:0] cs, input logic [63:0] td,
                                            input logic [63:0] rc, input int frac);
    return (cs * td * rc) >> frac;
  endfunction

  // Integrating current loop with clamping.
  function automatic logic [31:0] comi_step(input logic [31:0] cur, input logic [31:0] est,
                                            input logic [31:0] refv, input int sh,
                                            input logic [31:0] hi);
    logic signed [31:0] e;
    logic signed [31:0] n;
    e = $signed(refv) - $signed(est);
    n = $signed(cur) + (e >>> sh);
    if (n < 0) n = 0;
    else if (n > $signed(hi)) n = $signed(hi);
    return n;
  endfunction

endpackage

// File: rtl/fb_cycle_timer.sv
module fb_cycle_timer import fb_iest_pkg::*; #(
  parameter int CNT_W   = 16,
  parameter int ADC_W   = 12,
  parameter int BLANK   = 4,
  parameter int DEF_TON = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate,
  input  logic [ADC_W-1:0] cs_in,
  output logic             rise,
  output logic             fall,
  output logic             blank,
  output logic [CNT_W-1:0] off_pos,
  output logic [CNT_W-1:0] off_cnt,
  output logic             cs_load,
  output logic [ADC_W-1:0] cs_snap,
  output logic [CNT_W:0]   period_raw,
  output logic             cyc_done
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic             gate_q;
  logic             seen_fall;
  logic [CNT_W-1:0] on_cnt;
  logic [CNT_W-1:0] ton_last;
  logic [CNT_W-1:0] on_pos;
  logic [CNT_W-1:0] mid_tgt;
  logic [ADC_W-1:0] cs_mid;

  assign rise    = gate & ~gate_q;
  assign fall    = ~gate & gate_q;
  assign on_pos  = rise ? CNT_W'(1) : ((on_cnt == CMAX) ? CMAX : on_cnt + 1'b1);
  assign off_pos = fall ? CNT_W'(1) : ((off_cnt == CMAX) ? CMAX : off_cnt + 1'b1);
  assign blank   = gate ? (on_pos <= CNT_W'(BLANK)) : (off_pos <= CNT_W'(BLANK));
  assign mid_tgt = CNT_W'(pos_floor(32'(ton_last >> 1), 32'(BLANK + 1)));
  assign cs_load = gate & (on_pos == mid_tgt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_q     <= 1'b0;
      seen_fall  <= 1'b0;
      on_cnt     <= '0;
      off_cnt    <= '0;
      ton_last   <= CNT_W'(DEF_TON);
      cs_mid     <= '0;
      cs_snap    <= '0;
      period_raw <= '0;
      cyc_done   <= 1'b0;
    end else begin
      gate_q   <= gate;
      cyc_done <= 1'b0;
      if (gate) on_cnt <= on_pos;
      else      off_cnt <= off_pos;
      if (fall) begin
        ton_last  <= on_cnt;
        seen_fall <= 1'b1;
      end
      if (cs_load) cs_mid <= cs_in;
      if (rise) begin
        cs_snap    <= cs_mid;
        period_raw <= {1'b0, ton_last} + {1'b0, off_cnt};
        cyc_done   <= seen_fall;
      end
    end
  end
endmodule

// File: rtl/fb_knee_zcd.sv
module fb_knee_zcd import fb_iest_pkg::*; #(
  parameter int CNT_W    = 16,
  parameter int ADC_W    = 12,
  parameter int BLANK    = 4,
  parameter int DEF_KNEE = 16,
  parameter int KNEE_NUM = 218,
  parameter int KNEE_SH  = 8,
  parameter int MARGIN   = 164
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate,
  input  logic             rise,
  input  logic             fall,
  input  logic [CNT_W-1:0] off_pos,
  input  logic [CNT_W-1:0] off_cnt,
  input  logic [ADC_W-1:0] vs_in,
  output logic [CNT_W-1:0] tdis,
  output logic             vsh_load,
  output logic             zcd_hit
);
  localparam int AW = ADC_W + 1;

  logic             dis_active;
  logic             vsh_ok;
  logic             tdis_ok;
  logic [ADC_W-1:0] vsh;
  logic [CNT_W-1:0] knee_want;
  logic [CNT_W-1:0] knee_tgt;
  logic             drop_seen;

  assign knee_want = tdis_ok ? CNT_W'(knee_delay(32'(tdis), 32'(KNEE_NUM), KNEE_SH))
                             : CNT_W'(DEF_KNEE);
  assign knee_tgt  = CNT_W'(pos_floor(32'(knee_want), 32'(BLANK + 1)));
  assign vsh_load  = dis_active & ~gate & (off_pos == knee_tgt);
  assign drop_seen = (AW'(vs_in) + AW'(MARGIN)) < AW'(vsh);
  assign zcd_hit   = dis_active & ~gate & vsh_ok & ~vsh_load & drop_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dis_active <= 1'b0;
      vsh_ok     <= 1'b0;
      tdis_ok    <= 1'b0;
      vsh        <= '0;
      tdis       <= '0;
    end else if (fall) begin
      dis_active <= 1'b1;
      vsh_ok     <= 1'b0;
    end else if (rise && dis_active) begin
      tdis       <= off_cnt;
      tdis_ok    <= 1'b1;
      dis_active <= 1'b0;
    end else begin
      if (vsh_load) begin
        vsh    <= vs_in;
        vsh_ok <= 1'b1;
      end
      if (zcd_hit) begin
        tdis       <= off_pos;
        tdis_ok    <= 1'b1;
        dis_active <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fb_iout_calc.sv
module fb_iout_calc import fb_iest_pkg::*; #(
  parameter int ADC_W = 12,
  parameter int CNT_W = 16,
  parameter int PMIN  = 16,
  parameter int PMAX  = 1023,
  parameter int FRAC  = 16,
  parameter int IREF  = 2048,
  parameter int KI_SH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_done,
  input  logic [ADC_W-1:0] cs_snap,
  input  logic [CNT_W-1:0] tdis,
  input  logic [CNT_W:0]   period_raw,
  output logic [ADC_W-1:0] iout,
  output logic [ADC_W-1:0] comi,
  output logic             est_valid
);
  localparam int NT       = PMAX - PMIN + 1;
  localparam int IW       = $clog2(NT);
  localparam int RW       = FRAC + 1;
  localparam int COMI_MAX = (1 << ADC_W) - 1;

  logic [RW-1:0]    rtab [NT];
  logic [CNT_W:0]   pc;
  logic [IW-1:0]    idx;
  logic [ADC_W-1:0] est;
  logic [ADC_W-1:0] comi_nxt;

  for (genvar g = 0; g < NT; g++) begin : g_recip
    assign rtab[g] = RW'((1 << FRAC) / (g + PMIN));
  end

  assign pc  = (period_raw < (CNT_W+1)'(PMIN)) ? (CNT_W+1)'(PMIN) :
               (period_raw > (CNT_W+1)'(PMAX)) ? (CNT_W+1)'(PMAX) : period_raw;
  assign idx = IW'(pc - (CNT_W+1)'(PMIN));
  assign est = ADC_W'(scale_est(64'(cs_snap), 64'(tdis), 64'(rtab[idx]), FRAC));
  assign comi_nxt = ADC_W'(comi_step(32'(comi), 32'(est), 32'(IREF), KI_SH, 32'(COMI_MAX)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iout      <= '0;
      comi      <= ADC_W'(COMI_MAX);
      est_valid <= 1'b0;
    end else begin
      est_valid <= cyc_done;
      if (cyc_done) begin
        iout <= est;
        comi <= comi_nxt;
      end
    end
  end
endmodule

// File: rtl/fb_loop_or.sv
module fb_loop_or #(
  parameter int ADC_W = 12
) (
  input  logic [ADC_W-1:0] saw,
  input  logic [ADC_W-1:0] comv,
  input  logic [ADC_W-1:0] comi,
  output logic             turn_off
);
  logic cv_trip;
  logic cc_trip;

  assign cv_trip  = saw >= comv;
  assign cc_trip  = saw >= comi;
  assign turn_off = cv_trip | cc_trip;
endmodule

// File: rtl/fb_iest.sv
module fb_iest #(
  parameter int ADC_W    = 12,
  parameter int CNT_W    = 16,
  parameter int BLANK    = 4,
  parameter int DEF_TON  = 16,
  parameter int DEF_KNEE = 16,
  parameter int KNEE_NUM = 218,
  parameter int KNEE_SH  = 8,
  parameter int MARGIN   = 164,
  parameter int PMIN     = 16,
  parameter int PMAX     = 1023,
  parameter int FRAC     = 16,
  parameter int IREF     = 2048,
  parameter int KI_SH    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate,
  input  logic [ADC_W-1:0] vs_smp,
  input  logic [ADC_W-1:0] cs_smp,
  input  logic [ADC_W-1:0] comv,
  input  logic [ADC_W-1:0] saw,
  output logic [CNT_W-1:0] tdis,
  output logic [ADC_W-1:0] iout,
  output logic [ADC_W-1:0] comi,
  output logic             est_valid,
  output logic             turn_off
);
  // Internal events, named for the checker.
  logic             rise;
  logic             fall;
  logic             blank;
  logic [CNT_W-1:0] off_pos;
  logic [CNT_W-1:0] off_cnt;
  logic             cs_load;
  logic [ADC_W-1:0] cs_snap;
  logic [CNT_W:0]   period_raw;
  logic             cyc_done;
  logic             vsh_load;
  logic             zcd_hit;

  fb_cycle_timer #(.CNT_W(CNT_W), .ADC_W(ADC_W), .BLANK(BLANK), .DEF_TON(DEF_TON)) timer_i (
    .clk(clk), .rst_n(rst_n), .gate(gate), .cs_in(cs_smp),
    .rise(rise), .fall(fall), .blank(blank), .off_pos(off_pos), .off_cnt(off_cnt),
    .cs_load(cs_load), .cs_snap(cs_snap), .period_raw(period_raw), .cyc_done(cyc_done)
  );

  fb_knee_zcd #(.CNT_W(CNT_W), .ADC_W(ADC_W), .BLANK(BLANK), .DEF_KNEE(DEF_KNEE),
                .KNEE_NUM(KNEE_NUM), .KNEE_SH(KNEE_SH), .MARGIN(MARGIN)) zcd_i (
    .clk(clk), .rst_n(rst_n), .gate(gate), .rise(rise), .fall(fall),
    .off_pos(off_pos), .off_cnt(off_cnt), .vs_in(vs_smp),
    .tdis(tdis), .vsh_load(vsh_load), .zcd_hit(zcd_hit)
  );

  fb_iout_calc #(.ADC_W(ADC_W), .CNT_W(CNT_W), .PMIN(PMIN), .PMAX(PMAX), .FRAC(FRAC),
                 .IREF(IREF), .KI_SH(KI_SH)) calc_i (
    .clk(clk), .rst_n(rst_n), .cyc_done(cyc_done), .cs_snap(cs_snap), .tdis(tdis),
    .period_raw(period_raw), .iout(iout), .comi(comi), .est_valid(est_valid)
  );

  fb_loop_or #(.ADC_W(ADC_W)) or_i (
    .saw(saw), .comv(comv), .comi(comi), .turn_off(turn_off)
  );
endmodule

// File: rtl/fb_iest_chk.sv
module fb_iest_chk #(
  parameter int ADC_W = 12,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gate,
  input logic             est_valid,
  input logic [ADC_W-1:0] comi,
  input logic [CNT_W-1:0] tdis,
  input logic [CNT_W:0]   period_raw,
  input logic [ADC_W-1:0] saw,
  input logic             turn_off,
  input logic             blank,
  input logic             vsh_load,
  input logic             zcd_hit,
  input logic             cs_load
);
  // R2
  cs_mid_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_load |-> (gate && !blank));

  // R3
  knee_ref_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vsh_load |-> !blank);

  // R6
  zcd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zcd_hit |-> !blank);

  // R5
  tdis_in_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    est_valid |-> ({1'b0, tdis} <= period_raw));

  // R7
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    est_valid |=> !est_valid);

  // R8
  comi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !est_valid |-> $stable(comi));

  // R9
  cc_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (saw >= comi) |-> turn_off);
endmodule

bind fb_iest fb_iest_chk #(.ADC_W(ADC_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .gate(gate), .est_valid(est_valid), .comi(comi),
  .tdis(tdis), .period_raw(period_raw), .saw(saw), .turn_off(turn_off),
  .blank(blank), .vsh_load(vsh_load), .zcd_hit(zcd_hit), .cs_load(cs_load)
);

// File: tb/fb_iest_tb_top.sv
module fb_iest_tb_top;
  localparam int BLANK = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gate = 1'b0;
  logic [11:0] vs_smp = '0;
  logic [11:0] cs_smp = '0;
  logic [11:0] comv = '0;
  logic [11:0] saw = '0;
  logic [15:0] tdis;
  logic [11:0] iout;
  logic [11:0] comi;
  logic        est_valid;
  logic        turn_off;

  int checks = 0;
  int errors = 0;

  typedef struct { int td; int est; int cm; } exp_t;
  exp_t sbq[$];

  // model state, from the requirements
  int m_ton_prev = 16;
  int m_td_prev = 0;
  bit m_td_ok = 0;
  int m_csmid = 0;
  int m_comi = 4095;

  always #2.5 clk = ~clk;

  fb_iest dut_i (
    .clk(clk), .rst_n(rst_n), .gate(gate), .vs_smp(vs_smp), .cs_smp(cs_smp),
    .comv(comv), .saw(saw), .tdis(tdis), .iout(iout), .comi(comi),
    .est_valid(est_valid), .turn_off(turn_off)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int vs_at(int j, int kn, int vpl, int drop);
    return (j < kn) ? vpl : vpl - drop;
  endfunction

  // Driver: predicts the cycle and pushes the expected record, then drives it.
  task automatic run_cycle(int ton, int toff, int kn, int cs0, int slope, int vpl, int drop);
    int mid, knee, td, vsh, p, rec, est, e;
    exp_t x;
    mid = (m_ton_prev / 2 > BLANK) ? m_ton_prev / 2 : BLANK + 1;
    if (mid <= ton) m_csmid = cs0 + slope * mid;
    m_ton_prev = ton;
    knee = m_td_ok ? (m_td_prev * 218) / 256 : 16;
    if (knee < BLANK + 1) knee = BLANK + 1;
    td = toff;
    if (knee <= toff) begin
      vsh = vs_at(knee, kn, vpl, drop);
      for (int j = knee + 1; j <= toff; j++) begin
        if (vs_at(j, kn, vpl, drop) + 164 < vsh) begin
          td = j;
          break;
        end
      end
    end
    m_td_prev = td;
    m_td_ok = 1;
    p = ton + toff;
    if (p < 16) p = 16;
    if (p > 1023) p = 1023;
    rec = 65536 / p;
    est = int'((longint'(m_csmid) * td * rec) >> 16);
    e = m_comi + ((2048 - est) >>> 2);
    m_comi = (e < 0) ? 0 : (e > 4095) ? 4095 : e;
    x.td = td; x.est = est; x.cm = m_comi;
    sbq.push_back(x);
    for (int i = 1; i <= ton; i++) begin
      @(negedge clk);
      gate = 1'b1;
      cs_smp = (i <= BLANK) ? 12'd4095 : 12'(cs0 + slope * i);
      vs_smp = '0;
    end
    for (int j = 1; j <= toff; j++) begin
      @(negedge clk);
      gate = 1'b0;
      cs_smp = (j <= BLANK) ? 12'd4095 : 12'd0;
      vs_smp = (j <= BLANK) ? 12'd0 : 12'(vs_at(j, kn, vpl, drop));
    end
  endtask

  // Monitor: pops one expected record per estimate strobe.
  always @(negedge clk) begin
    if (rst_n && est_valid) begin
      if (sbq.size() == 0) begin
        chk(1'b0, "R7 unexpected estimate", 1, 0);
      end else begin
        exp_t x;
        x = sbq.pop_front();
        chk(int'(tdis) == x.td, "R3 R4 R5 tdis", int'(tdis), x.td);
        chk(int'(iout) == x.est, "R2 R6 R7 iout", int'(iout), x.est);
        chk(int'(comi) == x.cm, "R8 comi", int'(comi), x.cm);
      end
    end
  end

  task automatic cmp_check(int cv, int sw, int exp_to, string tag);
    comv = 12'(cv);
    saw = 12'(sw);
    #1;
    chk(int'(turn_off) == exp_to, tag, int'(turn_off), exp_to);
  endtask

  initial begin
    #(5ns * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(tdis == 0, "R1 tdis in reset", int'(tdis), 0);
    chk(comi == 4095, "R1 comi in reset", int'(comi), 4095);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(tdis == 0, "R1 tdis", int'(tdis), 0);
    chk(iout == 0, "R1 iout", int'(iout), 0);
    chk(comi == 4095, "R1 comi", int'(comi), 4095);
    chk(est_valid == 0, "R1 est_valid", int'(est_valid), 0);
    // R9 voltage-loop path with comi at its top
    cmp_check(1000, 999, 0, "R9 below comv");
    cmp_check(1000, 1000, 1, "R9 at comv");
    cmp_check(4000, 3999, 0, "R9 below both");
    cmp_check(4000, 4001, 1, "R9 above comv");
    comv = '0; saw = '0;
    @(negedge clk);

    run_cycle(20, 30, 22, 1000, 40, 2500, 400);  // first cycle, defaults (R2 R3)
    run_cycle(24, 36, 26, 1500, 60, 2600, 400);  // DCM knee (R4)
    run_cycle(40, 40, 30, 2000, 30, 2400, 120);  // drop within margin (R4)
    run_cycle(30, 30, 45, 1800, 50, 2400, 500);  // no knee, continuous (R5)
    run_cycle(10, 30, 20, 500, 10, 2200, 400);   // mid target past on-time (R2)
    run_cycle(6, 8, 7, 1200, 100, 2000, 400);    // short period clamp (R7 R6)
    for (int k = 0; k < 4; k++) run_cycle(10, 50, 45, 3600, 40, 2500, 400); // comi falls (R8)

    // flush: one more rise to release the last estimate
    @(negedge clk); gate = 1'b1; cs_smp = '0;
    repeat (3) @(negedge clk);
    gate = 1'b0;
    repeat (6) @(negedge clk);
    chk(sbq.size() == 0, "R7 all estimates seen", sbq.size(), 0);

    // R9 current-loop path
    cmp_check(4095, m_comi - 1, 0, "R9 below comi");
    cmp_check(4095, m_comi, 1, "R9 at comi");
    cmp_check(100, 100, 1, "R9 comv lower");
    cmp_check(100, 99, 0, "R9 below both late");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule